// File: doc/BRIEF.md
# Valley-Switching Turn-On Timing Controller

This block decides the clock cycle in which the power switch of a quasi-resonant converter is turned on again. A gate-off event starts a sequence. The sequence first waits out a minimum blanking interval. It then looks for arming, meaning that the zero-crossing sense voltage is above its arm level. Once armed, it waits for a trigger, which is a falling crossing of the lower trigger level. A programmable extra blanking can begin at the first trigger so that later resonant valleys are used. After that extra blanking, a bounded waiting window is opened. When no arming is seen, an internal starter timer makes sure the switch is still turned on.

All intervals are counted in clock cycles. The gate-off event and both zero-crossing flags pass through two-flop synchronisers before edge detection. The current-sense-high flag and the extra-blanking count are synchronous inputs. The output is a one-cycle turn-on request.

The sequence is a state machine with these states:
- `ST_IDLE`: waits for a gate-off.
- `ST_BLANK`: minimum blanking.
- `ST_SEEK`: starter search, waiting for arming.
- `ST_ARMED`: waits for the first trigger.
- `ST_SKIP`: extra blanking, triggers ignored.
- `ST_WINDOW`: waiting window.
- `ST_DELAY`: valley delay.
- `ST_FIRE`: request cycle.

Its transitions are:
- IDLE→BLANK on a gate-off edge. A gate-off edge in any state also returns to BLANK.
- BLANK→ARMED when arming is seen at the end of blanking.
- BLANK→WINDOW when the block is unarmed and current sense is high.
- BLANK→SEEK when the block is unarmed and current sense is low.
- SEEK→ARMED when arming is seen.
- SEEK→FIRE when the starter expires.
- ARMED→DELAY on a trigger when the extra blanking is zero.
- ARMED→SKIP on a trigger when the extra blanking is nonzero.
- SKIP→WINDOW when the extra blanking ends.
- WINDOW→DELAY on a trigger.
- WINDOW→FIRE when the window expires.
- DELAY→FIRE when the valley delay ends.
- FIRE→IDLE.

Top module: `valley_turnon_ctrl`

## Requirements
- R1: After reset, `ton_req` is 0, and it stays 0 until a gate-off rising edge has been seen.
- R2: A rising edge of `gate_off` reaches the state machine two cycles after it is sampled, through the synchroniser. The machine then enters the minimum blanking, which lasts BLANK_CYC cycles.
- R3: Falling trigger edges inside the minimum blanking are ignored. An arm level that is present during blanking but gone at its end does not arm the block.
- R4: The block arms when `zc_arm` is high at the end of blanking, or at any later time while the starter search is running. A trigger is a 1→0 transition of `zc_above_trig`.
- R5: When the block is armed and `extra_blank` is 0, a trigger produces `ton_req` DELAY_CYC cycles after the trigger reaches the state machine. Counted from the clock edge that first samples the falling flag, this is 3+DELAY_CYC edges.
- R6: When `extra_blank` is nonzero, the first trigger starts a skip interval of min(`extra_blank`, EXT_MAX) cycles. The value is latched at that trigger, and triggers during the skip are ignored.
- R7: After the skip, a window of WAIT_CYC cycles opens. The first trigger inside it goes through the valley delay of R5. If no trigger arrives, the window expiry issues `ton_req` directly, 3+extra+WAIT_CYC edges after the first trigger was sampled.
- R8: When the block is unarmed and `cs_high` is 0 at the end of blanking, a starter runs for STARTER_CYC cycles. The request follows at edge 3+BLANK_CYC+STARTER_CYC after gate-off, unless arming is seen first.
- R9: When the block is unarmed and `cs_high` is 1 at the end of blanking, the waiting window opens at once. Its expiry fires at edge 3+BLANK_CYC+WAIT_CYC after gate-off, and a trigger inside it goes through the valley delay.
- R10: A new gate-off edge aborts any sequence in progress and restarts it from the minimum blanking. No request from the aborted sequence appears.
- R11: `ton_req` is high for exactly one clock cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gate_off | input | 1 | Gate turn-off event, asynchronous; its rising edge starts a sequence |
| zc_arm | input | 1 | Comparator flag: sense voltage above the arm level, asynchronous |
| zc_above_trig | input | 1 | Comparator flag: sense voltage above the trigger level, asynchronous |
| cs_high | input | 1 | Current-sense level high, synchronous |
| extra_blank | input | EXT_W | Extra blanking in cycles; 0 disables it |
| ton_req | output | 1 | One-cycle turn-on request |

## Verification
The assertions take the following for granted about the inputs:
- Comparator flags and gate-off hold each level for at least two clocks, so the synchronisers see every change.
- `cs_high` is stable around the end of blanking.
- `extra_blank` is stable at the first trigger.

The stimulus drives every input on falling clock edges. It holds each level for two or more cycles and sets `cs_high` and `extra_blank` before the gate-off edge that starts a sequence. This gives every expected request an exact clock edge, computed from the requirement latencies.

// File: rtl/vt_pkg.sv
package vt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BLANK,
        ST_SEEK,
        ST_ARMED,
        ST_SKIP,
        ST_WINDOW,
        ST_DELAY,
        ST_FIRE
    } vt_state_e;

    function automatic int vt_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/vt_sync.sv
module vt_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            logic [1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= 2'b00;
                else        chain <= {chain[0], din[i]};
            end
            assign dout[i] = chain[1];
        end
    endgenerate

endmodule

// File: rtl/vt_extcap.sv
module vt_extcap #(
    parameter int EXT_W   = 12,
    parameter int EXT_MAX = 4000,
    parameter int CW      = 13
) (
    input  logic [EXT_W-1:0] ext_in,
    output logic [CW-1:0]    ext_out
);

    logic [31:0] ext_wide;

    always_comb begin
        ext_wide = 32'(ext_in);
        if (ext_wide > 32'(EXT_MAX)) ext_out = CW'(EXT_MAX);
        else                         ext_out = CW'(ext_wide);
    end

    always_comb begin
        AST_EXT_CAP: assert (32'(ext_out) <= 32'(EXT_MAX)); // R6
    end

endmodule

// File: rtl/vt_fsm.sv
module vt_fsm
    import vt_pkg::*;
#(
    parameter int BLANK_CYC   = 88,
    parameter int STARTER_CYC = 5000,
    parameter int WAIT_CYC    = 325,
    parameter int DELAY_CYC   = 8,
    parameter int CW          = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gate_lvl,
    input  logic          arm_lvl,
    input  logic          trig_lvl,
    input  logic          cs_high,
    input  logic [CW-1:0] ext_cyc,
    output logic          ton_req
);

    localparam logic [CW-1:0] ONE       = CW'(1);
    localparam logic [CW-1:0] BLANK_END = CW'(BLANK_CYC - 1);
    localparam logic [CW-1:0] START_END = CW'(STARTER_CYC - 1);
    localparam logic [CW-1:0] WAIT_END  = CW'(WAIT_CYC - 1);
    localparam logic [CW-1:0] DELAY_END = CW'(DELAY_CYC - 1);

    vt_state_e     state, nxt;
    logic [CW-1:0] cnt;
    logic [CW-1:0] ext_lat;
    logic          gate_prev, trig_prev;
    logic          go, trig_fall;

    assign go        = gate_lvl & ~gate_prev;
    assign trig_fall = ~trig_lvl & trig_prev;

    // next-state logic
    always_comb begin
        nxt = state;
        if (go) begin
            nxt = ST_BLANK;
        end else begin
            unique case (state)
                ST_IDLE:   nxt = ST_IDLE;
                ST_BLANK:  if (cnt == BLANK_END)
                               nxt = arm_lvl ? ST_ARMED : (cs_high ? ST_WINDOW : ST_SEEK);
                ST_SEEK:   if (arm_lvl)                nxt = ST_ARMED;
                           else if (cnt == START_END)  nxt = ST_FIRE;
                ST_ARMED:  if (trig_fall)
                               nxt = (ext_cyc == '0) ? ST_DELAY : ST_SKIP;
                ST_SKIP:   if (cnt == ext_lat - ONE)   nxt = ST_WINDOW;
                ST_WINDOW: if (trig_fall)              nxt = ST_DELAY;
                           else if (cnt == WAIT_END)   nxt = ST_FIRE;
                ST_DELAY:  if (cnt == DELAY_END)       nxt = ST_FIRE;
                ST_FIRE:   nxt = ST_IDLE;
            endcase
        end
    end

    // state register, shared interval counter, edge history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            ext_lat   <= '0;
            gate_prev <= 1'b0;
            trig_prev <= 1'b0;
        end else begin
            state     <= nxt;
            gate_prev <= gate_lvl;
            trig_prev <= trig_lvl;
            if (go || nxt != state || nxt == ST_IDLE || nxt == ST_ARMED)
                cnt <= '0;
            else
                cnt <= cnt + ONE;
            if (state == ST_ARMED && nxt == ST_SKIP)
                ext_lat <= ext_cyc;
        end
    end

    // output process
    always_comb begin
        ton_req = (state == ST_FIRE);
    end

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ton_req |=> !ton_req); // R11

    AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (state == ST_BLANK && cnt == '0)); // R10

    AST_BLANK_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BLANK && !go) |=>
            (state inside {ST_BLANK, ST_SEEK, ST_ARMED, ST_WINDOW})); // R3

    AST_SKIP_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP && !go && cnt != ext_lat - ONE) |=> (state == ST_SKIP)); // R6

    AST_STARTER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEEK) |-> (cnt < CW'(STARTER_CYC))); // R8

    AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WINDOW) |-> (cnt < CW'(WAIT_CYC))); // R7

    AST_FIRE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ton_req) |-> ($past(state) inside {ST_SEEK, ST_WINDOW, ST_DELAY})); // R7

    AST_DELAY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DELAY && cnt == DELAY_END && !go) |=> ton_req); // R5

endmodule

// File: rtl/valley_turnon_ctrl.sv
module valley_turnon_ctrl
    import vt_pkg::*;
#(
    parameter int BLANK_CYC   = 88,
    parameter int STARTER_CYC = 5000,
    parameter int WAIT_CYC    = 325,
    parameter int DELAY_CYC   = 8,
    parameter int EXT_W       = 12,
    parameter int EXT_MAX     = 4000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_off,
    input  logic             zc_arm,
    input  logic             zc_above_trig,
    input  logic             cs_high,
    input  logic [EXT_W-1:0] extra_blank,
    output logic             ton_req
);

    localparam int MAXC = vt_max(vt_max(BLANK_CYC, STARTER_CYC),
                                 vt_max(vt_max(WAIT_CYC, DELAY_CYC), EXT_MAX));
    localparam int CW   = $clog2(MAXC + 1);

    logic [2:0]    sync_out;
    logic [CW-1:0] ext_cyc;

    vt_sync #(.W(3)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({gate_off, zc_arm, zc_above_trig}),
        .dout (sync_out)
    );

    vt_extcap #(.EXT_W(EXT_W), .EXT_MAX(EXT_MAX), .CW(CW)) u_cap (
        .ext_in (extra_blank),
        .ext_out(ext_cyc)
    );

    vt_fsm #(
        .BLANK_CYC  (BLANK_CYC),
        .STARTER_CYC(STARTER_CYC),
        .WAIT_CYC   (WAIT_CYC),
        .DELAY_CYC  (DELAY_CYC),
        .CW         (CW)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .gate_lvl(sync_out[2]),
        .arm_lvl (sync_out[1]),
        .trig_lvl(sync_out[0]),
        .cs_high (cs_high),
        .ext_cyc (ext_cyc),
        .ton_req (ton_req)
    );

endmodule

// File: tb/valley_turnon_ctrl_test.sv
module valley_turnon_ctrl_test;

    localparam int B = 10;
    localparam int S = 40;
    localparam int W = 20;
    localparam int D = 3;
    localparam int XMAX = 30;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gate_off = 1'b0;
    logic       zc_arm = 1'b0;
    logic       zc_above_trig = 1'b1;
    logic       cs_high = 1'b0;
    logic [7:0] extra_blank = 8'd0;
    logic       ton_req;

    int    cyc = 0;
    int    total = 0;
    int    fails = 0;
    bit    mon_on = 1'b0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    typedef struct {
        int    at;
        string tag;
    } exp_t;
    exp_t sbq[$];

    valley_turnon_ctrl #(
        .BLANK_CYC(B), .STARTER_CYC(S), .WAIT_CYC(W), .DELAY_CYC(D),
        .EXT_W(8), .EXT_MAX(XMAX)
    ) uut (
        .clk(clk), .rst_n(rst_n), .gate_off(gate_off), .zc_arm(zc_arm),
        .zc_above_trig(zc_above_trig), .cs_high(cs_high),
        .extra_blank(extra_blank), .ton_req(ton_req)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_at(input int at, input string tag);
        exp_t e;
        e.at = at;
        e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic pulse_gate();
        gate_off = 1'b1;
        tick(2);
        gate_off = 1'b0;
    endtask

    task automatic drain();
        while (sbq.size() != 0) tick(1);
        tick(4);
        zc_arm = 1'b0; zc_above_trig = 1'b1; cs_high = 1'b0; extra_blank = 8'd0;
        tick(4);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    // monitor: compares every request against the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (mon_on) begin
                if (ton_req) begin
                    total++;
                    if (sbq.size() == 0) begin
                        fails++;
                        $display("FAIL R11/%s: unexpected request at cycle %0d (expected none)", cur_tag, cyc);
                    end else begin
                        exp_t e;
                        e = sbq.pop_front();
                        if (e.at != cyc) begin
                            fails++;
                            $display("FAIL %s: request at cycle %0d, expected %0d", e.tag, cyc, e.at);
                        end
                    end
                end else if (sbq.size() != 0 && sbq[0].at < cyc) begin
                    exp_t e;
                    e = sbq.pop_front();
                    total++;
                    fails++;
                    $display("FAIL %s: no request, expected at cycle %0d (now %0d)", e.tag, e.at, cyc);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: run did not finish, actual hung, expected done");
        finish_run();
    end

    initial begin
        int c;
        int cf;
        bit idle_bad;

        // R1: reset state
        tick(3);
        total++;
        if (ton_req !== 1'b0) begin
            fails++;
            $display("FAIL R1: ton_req in reset = %b, expected 0", ton_req);
        end
        rst_n = 1'b1;
        tick(2);
        mon_on = 1'b1;

        // R1: no request without gate-off, even with flag activity
        idle_bad = 1'b0;
        for (int k = 0; k < 60; k++) begin
            if (k == 10) zc_arm = 1'b1;
            if (k == 20) zc_above_trig = 1'b0;
            if (k == 30) zc_above_trig = 1'b1;
            tick(1);
            if (ton_req) idle_bad = 1'b1;
        end
        total++;
        if (idle_bad) begin
            fails++;
            $display("FAIL R1: request while idle = 1, expected 0");
        end
        drain();

        // R8 / R2: starter fires when unarmed, current sense low
        cur_tag = "R8";
        c = cyc;
        expect_at(c + 3 + B + S, "R8");
        pulse_gate();
        drain();

        // R3 / R5: trigger in blanking ignored, then armed trigger with no extra blank
        cur_tag = "R5";
        zc_arm = 1'b1;
        c = cyc;
        pulse_gate();
        zc_above_trig = 1'b0;          // falls inside blanking: ignored (R3)
        tick(2);
        zc_above_trig = 1'b1;
        tick(12);
        cf = cyc;
        expect_at(cf + 3 + D, "R5");
        zc_above_trig = 1'b0;
        drain();

        // R3: arm seen only inside blanking does not arm -> starter
        cur_tag = "R3";
        zc_arm = 1'b1;
        c = cyc;
        expect_at(c + 3 + B + S, "R3");
        pulse_gate();
        tick(2);
        zc_arm = 1'b0;
        drain();

        // R4: arming during starter search, then trigger
        cur_tag = "R4";
        c = cyc;
        pulse_gate();
        tick(18);
        zc_arm = 1'b1;
        tick(10);
        cf = cyc;
        expect_at(cf + 3 + D, "R4");
        zc_above_trig = 1'b0;
        drain();

        // R6 / R7: extra blank 8, trigger in skip ignored, trigger in window
        cur_tag = "R6";
        zc_arm = 1'b1;
        extra_blank = 8'd8;
        pulse_gate();
        tick(14);
        cf = cyc;
        zc_above_trig = 1'b0;
        tick(2);
        zc_above_trig = 1'b1;
        tick(2);
        zc_above_trig = 1'b0;           // decided inside skip: ignored
        tick(2);
        zc_above_trig = 1'b1;
        tick(8);
        expect_at(cf + 14 + 3 + D, "R7");
        zc_above_trig = 1'b0;           // decided inside window
        drain();

        // R7: window expiry after extra blank 8
        cur_tag = "R7";
        zc_arm = 1'b1;
        extra_blank = 8'd8;
        pulse_gate();
        tick(14);
        cf = cyc;
        expect_at(cf + 3 + 8 + W, "R7");
        zc_above_trig = 1'b0;
        drain();

        // R6: extra blank clamped to the maximum
        cur_tag = "R6";
        zc_arm = 1'b1;
        extra_blank = 8'd200;
        pulse_gate();
        tick(14);
        cf = cyc;
        expect_at(cf + 3 + XMAX + W, "R6");
        zc_above_trig = 1'b0;
        drain();

        // R9: unarmed with current sense high, window expiry
        cur_tag = "R9";
        cs_high = 1'b1;
        c = cyc;
        expect_at(c + 3 + B + W, "R9");
        pulse_gate();
        drain();

        // R9: unarmed with current sense high, trigger inside window
        cs_high = 1'b1;
        c = cyc;
        pulse_gate();
        tick(16);
        cf = cyc;
        expect_at(cf + 3 + D, "R9");
        zc_above_trig = 1'b0;
        drain();

        // R10: second gate-off restarts during starter search
        cur_tag = "R10";
        pulse_gate();
        tick(28);
        c = cyc;
        expect_at(c + 3 + B + S, "R10");
        pulse_gate();
        drain();

        // R10: second gate-off restarts during the waiting window
        cs_high = 1'b1;
        pulse_gate();
        tick(18);
        c = cyc;
        expect_at(c + 3 + B + W, "R10");
        pulse_gate();
        drain();

        // R11: every request above was one cycle wide (monitor flags any extra cycle)
        total++;
        if (sbq.size() != 0) begin
            fails++;
            $display("FAIL R11: %0d pending requests, expected 0", sbq.size());
        end

        finish_run();
    end

endmodule